// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the bus-facing front end of a byte-wide 32K-location memory that is reached over a two-wire I2C bus. It runs from a system clock, brings the SCL and SDA lines into that clock domain, and detects START, repeated START and STOP from the synchronised samples. After a START it receives a device-select byte. It answers only when the upper four bits equal 4'b1010 and the lower three bits equal the `dev_sel_i` pins.

A write request carries a two-byte location, high byte first, followed by any number of data bytes. Each data byte goes to a synchronous single-port RAM through `mem_*` and is acknowledged. A read request needs no location of its own. It streams bytes from one internal pointer, which reads and writes share, until the master refuses a byte. To read from a chosen location, the master sends a write request that carries only the two location bytes, then issues a repeated START followed by a read request. While `wp_i` is high, data bytes are refused and memory is not changed.

The control is one state machine with these states:
- IDLE waits for a START.
- DEV receives the device-select byte.
- AHI receives the high location byte.
- ALO receives the low location byte.
- WDAT receives a data byte.
- ACK drives, or withholds, the acknowledge during the ninth clock.
- TX shifts a byte out.
- MACK samples the master's acknowledge.
- IGNORE stays off the bus.

The transitions are:
- START from any state goes to DEV. STOP from any state goes to IDLE.
- DEV goes to ACK on a match and to IGNORE on a mismatch.
- AHI, ALO and WDAT go to ACK at the end of their byte.
- ACK goes, at the falling edge of the ninth clock, to the follower chosen when the byte ended: AHI, ALO, WDAT, TX or IGNORE.
- TX goes to MACK after eight bits.
- MACK goes to TX when the master acknowledges and to IGNORE when it does not.

Top module: `i2c_mem_slave`

## Requirements
- R1: A START is SDA falling while SCL is high. It restarts the block in DEV from any state, including IGNORE. A STOP is SDA rising while SCL is high. It returns the block to IDLE with SDA released.
- R2: The device-select byte is 7 address bits, MSB first, followed by a direction bit (1 = read, 0 = write). It is acknowledged only when its upper four bits are 4'b1010 and its next three bits equal `dev_sel_i`. On a mismatch, SDA stays released and no memory access occurs until the next START or STOP.
- R3: Bytes move MSB first. The receiver acknowledges by holding SDA low for the whole ninth SCL pulse. The slave releases SDA after the falling edge of that pulse.
- R4: A write request takes a high location byte, then a low location byte, then data bytes. Bit 7 of the high byte is ignored. Each data byte is written to the current pointer with one `mem_we` pulse and is acknowledged.
- R5: The pointer advances by one at the falling edge of the ninth clock after each data byte that was written or sent. It wraps from 0x7FFF to 0x0000 and the burst continues.
- R6: A read request returns bytes starting at the pointer, which is the location after the last byte read or written.
- R7: A write request that ends (repeated START or STOP) right after the low location byte loads the pointer and produces no memory write.
- R8: When the master does not acknowledge a sent byte, the slave keeps SDA released and ignores further clocks until a START or STOP.
- R9: While `wp_i` is high at the end of a data byte, that byte is not acknowledged, memory and pointer are unchanged, and the slave ignores the bus until a START or STOP.
- R10: A repeated START inside a write burst ends it and a new device-select byte is accepted. The pointer keeps the value the burst left.
- R11: After reset, SDA is released, the memory strobes are low and the pointer is 0x0000.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | When high, the data line is pulled low (open drain) |
| dev_sel_i | input | 3 | Low three bits of the device-select address |
| wp_i | input | 1 | Write protect; high refuses data bytes |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable, qualifies `mem_en` |
| mem_addr | output | 15 | RAM location |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one clock after a read strobe |

## Verification
The embedded assertions check these properties every cycle:
- The SDA drive changes only while the synchronised SCL is low.
- Each RAM write is followed by an asserted acknowledge.
- The IGNORE state neither drives SDA nor touches the RAM.
- The pointer steps by exactly one and wraps at its top.

Only the bench's scenarios can show that:
- The address decode works and a START recovers from IGNORE.
- The high-byte-first location order holds and its bit 7 is dropped.
- The pointer is shared between current-address and random reads.
- The wrap is continued in real bursts.
- Protected bytes leave memory and pointer untouched.
- A master refusal silences the slave.

The bench checks these against a shadow copy of the memory.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } slv_state_t;

    localparam int BYTE_W    = 8;
    localparam int BITCNT_W  = 4;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sh[SYNC_STAGES-1];
            sda_q  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sh[SYNC_STAGES-1];
    assign sda_s     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_mem_ptr.sv
module i2c_mem_ptr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_nxt
);
    assign ptr_nxt = ptr + ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (inc)
            ptr <= ptr_nxt;
    end

    // R5: one step per advance request
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (ptr == ADDR_W'($past(ptr) + 1)));

    // R5: top location rolls over to zero
    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && (&ptr)) |=> (ptr == '0));

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int         ADDR_W      = 15,
    parameter int         SEL_W       = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [SEL_W-1:0]  dev_sel_i,
    input  logic              wp_i,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    slv_state_t          state, after_ack;
    logic [BITCNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]   shreg, txreg;
    logic [HI_W-1:0]     hi_byte;
    logic                ack_drive, inc_pend, mack_ok, rd_cap;
    logic                byte_done, dev_match, wr_fire, rd_now, rd_next;
    logic                ptr_load, ptr_adv;
    logic [ADDR_W-1:0]   ptr, ptr_nxt;

    assign byte_done = scl_fall && (bitcnt == LAST_BIT);
    assign dev_match = (shreg[7:1] == {DEV_PREFIX, dev_sel_i});
    assign wr_fire   = (state == ST_WDAT) && byte_done && !wp_i;
    assign rd_now    = (state == ST_DEV) && byte_done && dev_match && shreg[0];
    assign rd_next   = (state == ST_TX) && byte_done;
    assign ptr_load  = (state == ST_ALO) && byte_done;
    assign ptr_adv   = scl_fall && (((state == ST_ACK) && inc_pend) || (state == ST_MACK));

    i2c_mem_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load),
        .load_val({hi_byte, shreg}), .inc(ptr_adv),
        .ptr(ptr), .ptr_nxt(ptr_nxt)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '1;
            hi_byte   <= '0;
            ack_drive <= 1'b0;
            inc_pend  <= 1'b0;
            mack_ok   <= 1'b0;
            rd_cap    <= 1'b0;
        end else begin
            rd_cap <= rd_now | rd_next;
            if (rd_cap)
                txreg <= mem_rdata;
            if (start_det) begin
                state     <= ST_DEV;
                bitcnt    <= '0;
                ack_drive <= 1'b0;
                inc_pend  <= 1'b0;
            end else if (stop_det) begin
                state     <= ST_IDLE;
                ack_drive <= 1'b0;
                inc_pend  <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: begin
                    end
                    ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (scl_rise && bitcnt != LAST_BIT) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            state     <= ST_ACK;
                            ack_drive <= 1'b1;
                            inc_pend  <= 1'b0;
                            if (state == ST_DEV) begin
                                if (!dev_match) begin
                                    state     <= ST_IGNORE;
                                    ack_drive <= 1'b0;
                                end
                                after_ack <= shreg[0] ? ST_TX : ST_AHI;
                            end else if (state == ST_AHI) begin
                                hi_byte   <= shreg[HI_W-1:0];
                                after_ack <= ST_ALO;
                            end else if (state == ST_ALO) begin
                                after_ack <= ST_WDAT;
                            end else begin
                                ack_drive <= !wp_i;
                                inc_pend  <= !wp_i;
                                after_ack <= wp_i ? ST_IGNORE : ST_WDAT;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state     <= after_ack;
                            bitcnt    <= '0;
                            ack_drive <= 1'b0;
                            inc_pend  <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise)
                            bitcnt <= bitcnt + 1'b1;
                        else if (scl_fall) begin
                            if (bitcnt == LAST_BIT)
                                state <= ST_MACK;
                            else
                                txreg <= {txreg[BYTE_W-2:0], 1'b1};
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise)
                            mack_ok <= !sda_s;
                        else if (scl_fall) begin
                            state  <= mack_ok ? ST_TX : ST_IGNORE;
                            bitcnt <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe    = ((state == ST_ACK) && ack_drive) || ((state == ST_TX) && !txreg[BYTE_W-1]);
        mem_en    = wr_fire | rd_now | rd_next;
        mem_we    = wr_fire;
        mem_addr  = rd_next ? ptr_nxt : ptr;
        mem_wdata = shreg;
    end

    // R12: drive changes land in the SCL low phase
    assert_sda_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R4: every stored byte is acknowledged in the following ninth clock
    assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ((state == ST_ACK) && ack_drive));

    // R2 / R8: an ignoring slave stays off the bus and the RAM
    assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !mem_en));

    // R9: a protected byte is refused in its ninth clock
    assert_protect_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WDAT) && byte_done && wp_i && !start_det && !stop_det)
            |=> ((state == ST_ACK) && !sda_oe));

endmodule

// File: tb/i2c_mem_slave_tb_top.sv
module i2c_mem_slave_tb_top;

    localparam int Q      = 5;
    localparam int MEM_N  = 1024;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic wp = 1'b0;
    logic sda_oe, mem_en, mem_we;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic sda_line;

    always #5 clk = ~clk;

    assign sda_line = !(sda_oe || m_sda_low);

    i2c_mem_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .dev_sel_i(SEL), .wp_i(wp),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] ram     [0:MEM_N-1];
    logic [7:0] exp_mem [0:MEM_N-1];
    int wr_count = 0;
    int last_wr_addr = -1;
    int high_changes = 0;
    int oe_seen = 0;
    logic oe_prev = 1'b0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_ptr = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) ^ (i >> 3));
    endfunction

    function automatic logic [7:0] exp_at(input int a);
        return exp_mem[a & (MEM_N - 1)];
    endfunction

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            ram[i]     = pat(i);
            exp_mem[i] = pat(i);
        end
    end

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                ram[mem_addr[9:0]] <= mem_wdata;
                wr_count     <= wr_count + 1;
                last_wr_addr <= int'(mem_addr);
            end else
                mem_rdata <= ram[mem_addr[9:0]];
        end
        if (rst_n && (sda_oe != oe_prev) && m_scl)
            high_changes <= high_changes + 1;
        if (sda_oe)
            oe_seen <= oe_seen + 1;
        oe_prev <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wait_q(1);
        m_scl = 1'b1;     wait_q(1);
        m_sda_low = 1'b1; wait_q(1);
        m_scl = 1'b0;     wait_q(1);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wait_q(1);
        m_scl = 1'b1;     wait_q(1);
        m_sda_low = 1'b0; wait_q(2);
    endtask

    task automatic put_bit(input bit b);
        m_sda_low = !b; wait_q(1);
        m_scl = 1'b1;   wait_q(2);
        m_scl = 1'b0;   wait_q(1);
    endtask

    task automatic get_bit(output bit b);
        m_sda_low = 1'b0; wait_q(1);
        m_scl = 1'b1;     wait_q(1);
        b = sda_line;     wait_q(1);
        m_scl = 1'b0;     wait_q(1);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!give_ack);
    endtask

    // start + write select + two location bytes; no stop
    task automatic set_addr(input int a, input bit top, output bit ok);
        bit a0, a1, a2;
        bus_start();
        send_byte({4'b1010, SEL, 1'b0}, a0);
        send_byte({top, 7'(a >> 8)}, a1);
        send_byte(8'(a), a2);
        ok = a0 && a1 && a2;
    endtask

    task automatic write_burst(input int a, input int n, input bit top, output bit addr_ok,
                               output bit all_ack);
        bit ack;
        logic [7:0] d;
        set_addr(a, top, addr_ok);
        all_ack = 1'b1;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            if (ack) exp_mem[(a + i) & (MEM_N - 1)] = d;
            all_ack = all_ack && ack;
        end
        bus_stop();
        exp_ptr = (a + n) & 32'h7FFF;
    endtask

    // read n bytes from the current pointer and compare with the shadow
    task automatic read_cur(input int n, input string req);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ack);
        chk(ack, {req, " read select ACK"}, int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == exp_at(exp_ptr), {req, " R3 read data"}, int'(d), int'(exp_at(exp_ptr)));
            exp_ptr = (exp_ptr + 1) & 32'h7FFF;
        end
        bus_stop();
    endtask

    initial begin
        bit ok, ack_all, ack;
        int w0;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        wait_q(4);
        rst_n = 1'b1;
        wait_q(2);

        // R11: reset state
        chk(sda_oe == 1'b0, "R11 sda released", int'(sda_oe), 0);
        chk(mem_en == 1'b0, "R11 memory idle", int'(mem_en), 0);
        read_cur(2, "R11 pointer zero / R6");

        // R2: wrong select bits, then R1: START recovers
        w0 = wr_count;
        bus_start();
        send_byte({4'b1010, ~SEL, 1'b0}, ack);
        chk(!ack, "R2 mismatch not acked", int'(ack), 0);
        send_byte(8'h01, ack);
        chk(!ack, "R2 ignored byte not acked", int'(ack), 0);
        send_byte(8'h55, ack);
        chk(wr_count == w0, "R2 no memory access", wr_count - w0, 0);
        bus_start();
        send_byte({4'b1010, SEL, 1'b0}, ack);
        chk(ack, "R1 START leaves ignore", int'(ack), 1);
        bus_stop();
        chk(sda_oe == 1'b0, "R1 STOP releases", int'(sda_oe), 0);

        // R4: burst with bit 7 of high byte set
        w0 = wr_count;
        write_burst(32'h0100, 4, 1'b1, ok, ack_all);
        chk(ok, "R4 location bytes acked", int'(ok), 1);
        chk(ack_all, "R4 data bytes acked", int'(ack_all), 1);
        chk(wr_count - w0 == 4, "R4 one write per byte", wr_count - w0, 4);
        chk(last_wr_addr == 32'h0103, "R4 top bit ignored", last_wr_addr, 32'h0103);

        // R7: random read via aborted write
        w0 = wr_count;
        set_addr(32'h0100, 1'b0, ok);
        exp_ptr = 32'h0100;
        read_cur(4, "R7 random read");
        chk(wr_count == w0, "R7 no write on address-only", wr_count - w0, 0);

        // R6 / R5: current-address read continues after last byte read
        read_cur(1, "R6 current address");

        // R5: wrap at top of array
        write_burst(32'h7FFE, 3, 1'b0, ok, ack_all);
        chk(ack_all, "R5 burst over top acked", int'(ack_all), 1);
        chk(last_wr_addr == 0, "R5 wrap to zero", last_wr_addr, 0);
        set_addr(32'h7FFF, 1'b0, ok);
        exp_ptr = 32'h7FFF;
        read_cur(2, "R5 read across wrap");

        // R9: write protect
        wp = 1'b1;
        w0 = wr_count;
        set_addr(32'h0200, 1'b0, ok);
        send_byte(8'hA5, ack);
        chk(!ack, "R9 protected byte refused", int'(ack), 0);
        send_byte(8'h5A, ack);
        chk(!ack, "R9 ignored after refusal", int'(ack), 0);
        bus_stop();
        wp = 1'b0;
        chk(wr_count == w0, "R9 memory unchanged", wr_count - w0, 0);
        exp_ptr = 32'h0200;
        read_cur(1, "R9 pointer and data unchanged");

        // R8: master refusal silences the slave
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ack);
        recv_byte(1'b0, d);
        chk(d == exp_at(exp_ptr), "R8 data before refusal", int'(d), int'(exp_at(exp_ptr)));
        exp_ptr = (exp_ptr + 1) & 32'h7FFF;
        w0 = oe_seen;
        for (int i = 0; i < 9; i++) begin
            bit b;
            get_bit(b);
        end
        chk(oe_seen == w0, "R8 SDA stays released", oe_seen - w0, 0);
        bus_stop();

        // R10: repeated START inside a burst
        set_addr(32'h0300, 1'b0, ok);
        d = 8'h3C;
        send_byte(d, ack);
        exp_mem[32'h0300 & (MEM_N - 1)] = d;
        exp_ptr = 32'h0301;
        read_cur(1, "R10 repeated START keeps pointer");
        exp_ptr = 32'h0300;
        set_addr(32'h0300, 1'b0, ok);
        read_cur(1, "R10 burst byte stored");

        // random bursts and read-backs
        for (int t = 0; t < 16; t++) begin
            int a, n;
            a = int'($urandom & 32'h7FFF);
            n = 1 + int'($urandom % 6);
            write_burst(a, n, 1'($urandom), ok, ack_all);
            chk(ok && ack_all, "R4 random burst acked", int'(ok && ack_all), 1);
            set_addr(a, 1'b0, ok);
            exp_ptr = a;
            read_cur(n, "R6 random read-back");
        end

        chk(high_changes == 0, "R12 drive change while SCL high", high_changes, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule